// File: doc/BRIEF.md
# Three-Master Round-Robin Bus Arbiter

This block decides which of three bus masters owns a shared bus. A fourth owner value, the default owner, holds the bus whenever no master does. Each master drives a request line, its own transfer-type code and a status code (idle, write phase, or anything else). The arbiter keeps one owner register. From it the block drives a one-hot grant vector and an encoded owner field, and it routes the owning master's transfer type onto the bus.

Ownership moves only at transaction boundaries. A holder gives the bus up when it is in its write phase and the bus shows an IDLE or BUSY transfer. It also gives the bus up when it is idle, shows IDLE and has dropped its own request. The successor is the first requester after the holder in rotating order. When nobody is requesting, the bus returns to the default owner. When the bus is unowned and several masters request at once, a rotating pointer chooses among them.

Top module: `rr_bus_arbiter`

## Requirements
- R1: After reset the owner field reads the default code (3), all grants are low and the bus transfer type is IDLE.
- R2: Grant bit i is high exactly when the owner field equals i, for i = 0, 1, 2. At most one grant is ever high.
- R3: While the owner is default and exactly one request is high, that master becomes the owner on the next clock.
- R4: While the owner is default and several requests are high, the next owner is the first requester found by scanning upward with wrap, starting at a pointer. The pointer resets to master 0. Each time a master is newly granted, the pointer is set to the master after it.
- R5: When the holder's status is write (01) and the bus transfer is IDLE (00) or BUSY (01), the next owner is the first other requester after the holder in rotating order (0→1→2→0). If no master requests at all, the owner becomes default.
- R6: When the holder's status is idle (00), the bus transfer is IDLE and the holder's own request is low, the grant passes to the first other requester after the holder in rotating order.
- R7: When a master holds the bus, the bus transfer is IDLE and no request is high, the owner becomes default on the next clock.
- R8: The bus transfer type equals the owning master's transfer code. It is IDLE while the owner is default. The transfer codes are IDLE=00, BUSY=01 and NONSEQ=10. The status codes are idle=00, write=01 and other=10.
- R9: In every other case the owner holds its value. This includes any NONSEQ transfer, and a release point at which the holder is the only requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Bus request per master |
| mst_trans_i | input | 6 | Transfer code per master, 2 bits each, master i at bits 2i+1:2i |
| mst_stat_i | input | 6 | Status code per master, 2 bits each, master i at bits 2i+1:2i |
| gnt_o | output | 3 | One-hot grant per master |
| owner_o | output | 2 | Current owner: 0..2 for a master, 3 for default |
| bus_trans_o | output | 2 | Transfer type of the current owner |

## Verification
The bench builds the arbiter with its default of three masters. With three masters every rotation path can be reached: each holder has two possible successors, and the wrap from master 2 back to master 0 occurs. The owner field is two bits wide, so the default code 3 uses the last free encoding. Directed steps cover each release rule, the case where the holder is the only requester, and a three-way tie from default. A long run of seeded random request, status and transfer patterns then checks the owner, the grants and the routed transfer type against a reference model, once per cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  localparam logic [1:0] ST_IDLE  = 2'b00;
  localparam logic [1:0] ST_WRITE = 2'b01;
  localparam logic [1:0] ST_OTHER = 2'b10;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_MST = 3,
  parameter int IW    = 2
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IW-1:0]    start_i,
  output logic             found_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N_MST; k++) begin
      int j;
      j = int'(start_i) + k;
      if (j >= N_MST) j = j - N_MST;
      if (j >= N_MST) j = j - N_MST;
      if (!found_o && req_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_trans_mux.sv
module arb_trans_mux #(
  parameter int N_MST = 3,
  parameter int IW    = 2
) (
  input  logic [IW-1:0]      owner_i,
  input  logic [2*N_MST-1:0] mst_trans_i,
  output logic [1:0]         bus_trans_o
);
  import arb_pkg::*;
  always_comb begin
    bus_trans_o = TR_IDLE;
    for (int i = 0; i < N_MST; i++)
      if (owner_i == IW'(i)) bus_trans_o = mst_trans_i[2*i +: 2];
  end
endmodule

// File: rtl/arb_gnt_dec.sv
module arb_gnt_dec #(
  parameter int N_MST = 3,
  parameter int IW    = 2
) (
  input  logic [IW-1:0]    owner_i,
  output logic [N_MST-1:0] gnt_o
);
  for (genvar i = 0; i < N_MST; i++) begin : g_dec
    assign gnt_o[i] = (owner_i == IW'(i));
  end
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int N_MST = 3,
  localparam int OWN_W = $clog2(N_MST + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MST-1:0]   req_i,
  input  logic [2*N_MST-1:0] mst_trans_i,
  input  logic [2*N_MST-1:0] mst_stat_i,
  output logic [N_MST-1:0]   gnt_o,
  output logic [OWN_W-1:0]   owner_o,
  output logic [1:0]         bus_trans_o
);
  import arb_pkg::*;

  localparam logic [OWN_W-1:0] DEF_OWN = OWN_W'(N_MST);
  localparam logic [OWN_W-1:0] LAST    = OWN_W'(N_MST - 1);

  logic [OWN_W-1:0] own_q, own_d, ptr_q, ptr_d, nxt_start;
  logic [N_MST-1:0] own_mask, req_oth;
  logic [1:0]       hold_stat;
  logic             hold_req, is_def, rel_pt;
  logic             idle_found, hand_found;
  logic [OWN_W-1:0] idle_idx, hand_idx;

  assign is_def    = (own_q == DEF_OWN);
  assign nxt_start = (own_q == LAST) ? '0 : own_q + 1'b1;

  always_comb begin
    hold_stat = ST_OTHER;
    hold_req  = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      own_mask[i] = (own_q == OWN_W'(i));
      if (own_mask[i]) begin
        hold_stat = mst_stat_i[2*i +: 2];
        hold_req  = req_i[i];
      end
    end
  end
  assign req_oth = req_i & ~own_mask;

  arb_rr_pick #(.N_MST(N_MST), .IW(OWN_W)) u_pick_idle (
    .req_i(req_i), .start_i(ptr_q), .found_o(idle_found), .idx_o(idle_idx));

  arb_rr_pick #(.N_MST(N_MST), .IW(OWN_W)) u_pick_hand (
    .req_i(req_oth), .start_i(nxt_start), .found_o(hand_found), .idx_o(hand_idx));

  arb_trans_mux #(.N_MST(N_MST), .IW(OWN_W)) u_mux (
    .owner_i(own_q), .mst_trans_i(mst_trans_i), .bus_trans_o(bus_trans_o));

  arb_gnt_dec #(.N_MST(N_MST), .IW(OWN_W)) u_dec (
    .owner_i(own_q), .gnt_o(gnt_o));

  assign rel_pt = (hold_stat == ST_WRITE) &&
                  (bus_trans_o == TR_IDLE || bus_trans_o == TR_BUSY);

  always_comb begin
    own_d = own_q;
    ptr_d = ptr_q;
    if (is_def) begin
      if (idle_found) own_d = idle_idx;
    end else if (rel_pt) begin
      if (hand_found)       own_d = hand_idx;
      else if (req_i == '0) own_d = DEF_OWN;
    end else if (hold_stat == ST_IDLE && bus_trans_o == TR_IDLE && !hold_req && hand_found) begin
      own_d = hand_idx;
    end else if (bus_trans_o == TR_IDLE && req_i == '0) begin
      own_d = DEF_OWN;
    end
    // pointer moves past every newly granted master
    if (own_d != own_q && own_d != DEF_OWN)
      ptr_d = (own_d == LAST) ? '0 : own_d + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= DEF_OWN;
      ptr_q <= '0;
    end else begin
      own_q <= own_d;
      ptr_q <= ptr_d;
    end
  end

  assign owner_o = own_q;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N_MST = 3,
  localparam int OWN_W = $clog2(N_MST + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic [N_MST-1:0] gnt_o,
  input logic [OWN_W-1:0] owner_o,
  input logic [1:0]       bus_trans_o
);
  localparam logic [OWN_W-1:0] DEF_OWN = OWN_W'(N_MST);

  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R2
  gnt_none_def_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |-> (owner_o == DEF_OWN));

  // R3
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == DEF_OWN && $countones(req_i) == 1) |=> (gnt_o == $past(req_i)));

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o != DEF_OWN && bus_trans_o == 2'b00 && req_i == '0) |=> (owner_o == DEF_OWN));

  // R8
  def_trans_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == DEF_OWN) |-> (bus_trans_o == 2'b00));

  // R9
  nonseq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o != DEF_OWN && bus_trans_o == 2'b10) |=> $stable(owner_o));
endmodule

bind rr_bus_arbiter arb_chk #(.N_MST(N_MST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o),
  .owner_o(owner_o), .bus_trans_o(bus_trans_o));

// File: tb/rr_bus_arbiter_tb.sv
`timescale 1ns/1ps
module rr_bus_arbiter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req_i = '0;
  logic [5:0] mst_trans_i = '0;
  logic [5:0] mst_stat_i = '0;
  logic [2:0] gnt_o;
  logic [1:0] owner_o;
  logic [1:0] bus_trans_o;

  int n_chk = 0, n_err = 0;
  int m_own = 3, m_ptr = 0, m_rule = 1;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rr_bus_arbiter u_dut (.*);

  function automatic string tag(input int r);
    return $sformatf("R%0d", r);
  endfunction

  function automatic void step(input int own, input int ptr, input logic [2:0] rq,
                               input logic [5:0] tr, input logic [5:0] st,
                               output int nown, output int nptr, output int rule);
    int btr, hst, hand;
    bit hrq;
    nown = own; nptr = ptr; rule = 9;
    if (own == 3) begin
      for (int k = 0; k < 3; k++) begin
        int j;
        j = (ptr + k) % 3;
        if (rq[j] && nown == 3) begin
          nown = j;
          rule = ($countones(rq) == 1) ? 3 : 4;
        end
      end
    end else begin
      btr = int'(tr[2*own +: 2]);
      hst = int'(st[2*own +: 2]);
      hrq = rq[own];
      hand = -1;
      for (int k = 1; k < 3; k++) begin
        int j;
        j = (own + k) % 3;
        if (rq[j] && hand < 0) hand = j;
      end
      if (hst == 1 && (btr == 0 || btr == 1)) begin
        if (hand >= 0)      begin nown = hand; rule = 5; end
        else if (rq == 0)   begin nown = 3;    rule = 5; end
      end else if (hst == 0 && btr == 0 && !hrq && hand >= 0) begin
        nown = hand; rule = 6;
      end else if (btr == 0 && rq == 0) begin
        nown = 3; rule = 7;
      end
    end
    if (nown != own && nown != 3) nptr = (nown + 1) % 3;
  endfunction

  task automatic check_outputs();
    logic [2:0] eg;
    logic [1:0] et;
    eg = (m_own < 3) ? 3'(1 << m_own) : 3'b000;
    et = (m_own < 3) ? mst_trans_i[2*m_own +: 2] : 2'b00;
    n_chk++;
    if (owner_o != 2'(m_own)) begin
      n_err++;
      $display("FAIL %s owner: actual %0d expected %0d", tag(m_rule), owner_o, m_own);
    end
    n_chk++;
    if (gnt_o != eg) begin
      n_err++;
      $display("FAIL R2 grants: actual %b expected %b", gnt_o, eg);
    end
    n_chk++;
    if (bus_trans_o != et) begin
      n_err++;
      $display("FAIL R8 bus transfer: actual %b expected %b", bus_trans_o, et);
    end
  endtask

  task automatic cyc(input logic [2:0] rq, input logic [5:0] tr, input logic [5:0] st);
    int nown, nptr, rule;
    @(negedge clk_i);
    req_i = rq; mst_trans_i = tr; mst_stat_i = st;
    #1;
    check_outputs();
    step(m_own, m_ptr, rq, tr, st, nown, nptr, rule);
    @(posedge clk_i);
    m_own = nown; m_ptr = nptr; m_rule = rule;
  endtask

  // transfer / status codes: IDLE 00, BUSY 01, NONSEQ 10 ; idle 00, write 01, other 10
  initial begin
    void'($urandom(32'h5eed_1234));
    #22;
    // R1 reset state
    n_chk++;
    if (owner_o != 2'd3 || gnt_o != 3'b000 || bus_trans_o != 2'b00) begin
      n_err++;
      $display("FAIL R1 reset: actual owner %0d gnt %b trans %b expected 3 000 00",
               owner_o, gnt_o, bus_trans_o);
    end
    rst_ni = 1'b1;
    // R3 single request from default
    cyc(3'b010, 6'b10_10_10, 6'b10_10_10);
    // R5 master1 write+BUSY, others 0,2 -> master2
    cyc(3'b101, 6'b10_01_10, 6'b10_01_10);
    // R5 master2 write+IDLE, reqs 0,1 -> wrap to master0
    cyc(3'b011, 6'b00_10_10, 6'b01_10_10);
    // R9 master0 at release point, sole requester -> hold
    cyc(3'b001, 6'b10_10_00, 6'b10_10_01);
    // R6 master0 idle, IDLE, dropped request -> master1
    cyc(3'b010, 6'b10_10_00, 6'b10_10_00);
    // R7 master1 other, IDLE, no requests -> default
    cyc(3'b000, 6'b10_00_10, 6'b10_10_10);
    // R4 three-way tie, pointer at 2 -> master2
    cyc(3'b111, 6'b10_10_10, 6'b10_10_10);
    // R5 master2 write+BUSY, no requests -> default
    cyc(3'b000, 6'b01_10_10, 6'b01_10_10);
    // R4 tie 0,1 with pointer at 0 -> master0
    cyc(3'b011, 6'b10_10_10, 6'b10_10_10);
    cyc(3'b000, 6'b10_10_00, 6'b10_10_10);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] tr, st;
      for (int i = 0; i < 3; i++) begin
        tr[2*i +: 2] = 2'($urandom % 3);
        st[2*i +: 2] = 2'($urandom % 3);
      end
      cyc(3'($urandom % 8), tr, st);
    end
    cyc(3'b000, 6'b00_00_00, 6'b10_10_10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule